// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block stands in for the memory-device side of the DDR3 write-leveling step. While a mode-register flag holds leveling on, every rising edge of the data strobe (delivered to the block as a one-cycle event) captures the level of the memory clock as seen at that edge. That level is returned on the data bus after a programmable number of clock cycles. A low clock returns 0 and a high clock returns 1. A controller on the other side moves its strobe delay until the returned value flips, and so finds the strobe-to-clock alignment.

A static configuration input selects how the feedback is placed on the bus. It can go on one designated data bit, with every other bit held low, or it can be copied onto every data bit. The block also measures the strobe's high and low phases against programmable minimum widths and raises an error flag when a phase is too short. A command that leaves leveling starts a guard window of programmable length. During that window the bus stays released and a raised enable is not acted on.

All time quantities are whole clock cycles taken from configuration inputs. They must be held stable while leveling is on. Analog sampling and delay lines are not modelled.

Top module: `wlvl_responder`

## Requirements
- R1: After synchronous reset, dq is all zeros and dq_oe, dq_valid and pw_err are low.
- R2: When dqs_rise is sampled high on a clock edge while leveling is active, dq_valid is high for exactly one cycle, beginning out_lat clock edges after that capture edge, and the feedback shown then equals the ck_level sampled at the capture edge.
- R3: The feedback latency out_lat is programmable from 1 to 15 cycles; a value of 0 behaves as 1.
- R4: With fb_all low, the feedback appears on bit 0 of dq only and bits 7..1 stay 0 throughout.
- R5: With fb_all high, the feedback is copied onto all eight bits of dq (0x00 or 0xFF).
- R6: Between feedback events, while leveling stays active, dq keeps the most recent feedback value.
- R7: dq_oe goes high at the (oe_lat+1)-th consecutive clock edge at which leveling is active, and it goes low at the first edge at which leveling is inactive.
- R8: Leveling is active only while wl_en is high. When it goes inactive, dq_oe, dq_valid and dq drop to 0, and any feedback still in flight is discarded.
- R9: A falling strobe event that arrives fewer than min_high cycles after the preceding rising event sets pw_err. A distance of min_high or more does not set it.
- R10: A rising strobe event that arrives fewer than min_low cycles after the preceding falling event sets pw_err. A distance of min_low or more does not set it.
- R11: pw_err stays set while leveling remains active and clears at the first edge at which leveling is inactive.
- R12: At the edge where wl_exit is sampled high, and at the exit_hold edges that follow it, leveling is inactive whatever the level of wl_en. Leveling resumes at the next edge if wl_en is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_en | input | 1 | Leveling-mode enable flag from the mode register |
| wl_exit | input | 1 | One-cycle pulse marking the command that leaves leveling |
| fb_all | input | 1 | 1: feedback on all data bits, 0: on the prime bit only |
| ck_level | input | 1 | Clock level sampled at the strobe edge |
| dqs_rise | input | 1 | Rising strobe edge event |
| dqs_fall | input | 1 | Falling strobe edge event |
| out_lat | input | 4 | Feedback latency in cycles |
| oe_lat | input | 8 | Output-enable delay in cycles after leveling starts |
| min_high | input | 8 | Minimum strobe high width in cycles |
| min_low | input | 8 | Minimum strobe low width in cycles |
| exit_hold | input | 8 | Guard window length after an exit command |
| dq | output | 8 | Feedback data bus |
| dq_oe | output | 1 | Output enable for dq (low means released) |
| dq_valid | output | 1 | One-cycle marker of new feedback |
| pw_err | output | 1 | Strobe pulse-width violation flag |

## Verification
A rising strobe event can end a low phase that is too short and start a feedback capture in the same cycle. The pulse-width checker and the feedback pipeline then both act on one edge. The bench provokes this by sending a falling event and then a rising event one cycle later while min_low is 2. It judges the result by requiring pw_err to be high right after that edge. The feedback of the same edge must still arrive out_lat cycles later with the correct clock level on the prime bit.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  // one slot of the feedback latency line
  typedef struct packed {
    logic vld;
    logic lvl;
  } fb_slot_t;

endpackage

// File: rtl/wlvl_gate.sv
module wlvl_gate #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wl_en,
  input  logic             wl_exit,
  input  logic [CYC_W-1:0] oe_lat,
  input  logic [CYC_W-1:0] exit_hold,
  output logic             active,
  output logic             oe_q
);

  logic [CYC_W-1:0] hold_cnt;
  logic [CYC_W-1:0] age;

  // leveling runs only outside the exit guard window
  assign active = wl_en && !wl_exit && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      age      <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (wl_exit)
        hold_cnt <= exit_hold;
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;

      if (active) begin
        if (age != '1)
          age <= age + 1'b1;
        oe_q <= (age >= oe_lat);
      end else begin
        age  <= '0;
        oe_q <= 1'b0;
      end
    end
  end

  p_oe_off_after_disable_r7: assert property (@(posedge clk) disable iff (rst)
    !wl_en |=> !oe_q);

  p_exit_releases_bus_r12: assert property (@(posedge clk) disable iff (rst)
    wl_exit |=> !oe_q);

endmodule

// File: rtl/wlvl_fb_pipe.sv
module wlvl_fb_pipe
  import wlvl_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             dqs_rise,
  input  logic             ck_level,
  input  logic [LAT_W-1:0] out_lat,
  output logic             fb_vld,
  output logic             fb_lvl
);

  localparam int MAX_LAT = (1 << LAT_W) - 1;

  fb_slot_t         line_q [MAX_LAT];
  logic [LAT_W-1:0] tap_sel;
  fb_slot_t         tap;

  generate
    for (genvar g = 0; g < MAX_LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || !active)
            line_q[0] <= '0;
          else
            line_q[0] <= '{vld: dqs_rise, lvl: ck_level};
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst || !active)
            line_q[g] <= '0;
          else
            line_q[g] <= line_q[g-1];
        end
      end
    end
  endgenerate

  assign tap_sel = (out_lat == '0) ? '0 : out_lat - 1'b1;
  assign tap     = line_q[tap_sel];

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      fb_vld <= 1'b0;
      fb_lvl <= 1'b0;
    end else begin
      fb_vld <= tap.vld;
      if (tap.vld)
        fb_lvl <= tap.lvl;
    end
  end

  p_valid_needs_active_r2: assert property (@(posedge clk) disable iff (rst)
    fb_vld |-> $past(active));

  p_level_held_r6: assert property (@(posedge clk) disable iff (rst)
    (active && !tap.vld) |=> $stable(fb_lvl));

endmodule

// File: rtl/wlvl_pw_check.sv
module wlvl_pw_check #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             dqs_rise,
  input  logic             dqs_fall,
  input  logic [CYC_W-1:0] min_high,
  input  logic [CYC_W-1:0] min_low,
  output logic             err_q
);

  logic [CYC_W-1:0] since_edge;
  logic             armed;
  logic             strobe_hi;
  logic             any_edge;
  logic             short_hi;
  logic             short_lo;

  assign any_edge = dqs_rise || dqs_fall;
  assign short_hi = armed && strobe_hi  && dqs_fall && (since_edge < min_high);
  assign short_lo = armed && !strobe_hi && dqs_rise && (since_edge < min_low);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      since_edge <= '0;
      armed      <= 1'b0;
      strobe_hi  <= 1'b0;
      err_q      <= 1'b0;
    end else if (any_edge) begin
      since_edge <= {{(CYC_W-1){1'b0}}, 1'b1};
      armed      <= 1'b1;
      strobe_hi  <= dqs_rise;
      if (short_hi || short_lo)
        err_q <= 1'b1;
    end else if (since_edge != '1) begin
      since_edge <= since_edge + 1'b1;
    end
  end

  p_err_needs_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(any_edge));

  p_err_clears_r11: assert property (@(posedge clk) disable iff (rst)
    !active |=> !err_q);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_q && active) |=> err_q);

endmodule

// File: rtl/wlvl_responder.sv
module wlvl_responder #(
  parameter int DQ_W      = 8,
  parameter int PRIME_BIT = 0,
  parameter int LAT_W     = 4,
  parameter int CYC_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wl_en,
  input  logic             wl_exit,
  input  logic             fb_all,
  input  logic             ck_level,
  input  logic             dqs_rise,
  input  logic             dqs_fall,
  input  logic [LAT_W-1:0] out_lat,
  input  logic [CYC_W-1:0] oe_lat,
  input  logic [CYC_W-1:0] min_high,
  input  logic [CYC_W-1:0] min_low,
  input  logic [CYC_W-1:0] exit_hold,
  output logic [DQ_W-1:0]  dq,
  output logic             dq_oe,
  output logic             dq_valid,
  output logic             pw_err
);

  localparam logic [DQ_W-1:0] PRIME_MASK = DQ_W'(1) << PRIME_BIT;

  logic active;
  logic fb_lvl;

  wlvl_gate #(.CYC_W(CYC_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .wl_en     (wl_en),
    .wl_exit   (wl_exit),
    .oe_lat    (oe_lat),
    .exit_hold (exit_hold),
    .active    (active),
    .oe_q      (dq_oe)
  );

  wlvl_fb_pipe #(.LAT_W(LAT_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .dqs_rise (dqs_rise),
    .ck_level (ck_level),
    .out_lat  (out_lat),
    .fb_vld   (dq_valid),
    .fb_lvl   (fb_lvl)
  );

  wlvl_pw_check #(.CYC_W(CYC_W)) u_pw (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .dqs_rise (dqs_rise),
    .dqs_fall (dqs_fall),
    .min_high (min_high),
    .min_low  (min_low),
    .err_q    (pw_err)
  );

  // bus placement: prime bit always carries feedback, others only in all-bits mode
  generate
    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
      if (b == PRIME_BIT) begin : g_prime
        assign dq[b] = fb_lvl;
      end else begin : g_rest
        assign dq[b] = fb_all & fb_lvl;
      end
    end
  endgenerate

  p_prime_only_r4: assert property (@(posedge clk) disable iff (rst)
    !fb_all |-> ((dq & ~PRIME_MASK) == '0));

  p_all_bits_equal_r5: assert property (@(posedge clk) disable iff (rst)
    fb_all |-> (dq == '0 || dq == '1));

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !wl_en |=> (!dq_valid && dq == '0));

endmodule

// File: tb/tb_wlvl_responder.sv
module tb_wlvl_responder;

  logic       clk = 1'b0;
  logic       rst;
  logic       wl_en, wl_exit, fb_all, ck_level, dqs_rise, dqs_fall;
  logic [3:0] out_lat;
  logic [7:0] oe_lat, min_high, min_low, exit_hold;
  logic [7:0] dq;
  logic       dq_oe, dq_valid, pw_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wlvl_responder dut (
    .clk(clk), .rst(rst), .wl_en(wl_en), .wl_exit(wl_exit), .fb_all(fb_all),
    .ck_level(ck_level), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
    .out_lat(out_lat), .oe_lat(oe_lat), .min_high(min_high), .min_low(min_low),
    .exit_hold(exit_hold), .dq(dq), .dq_oe(dq_oe), .dq_valid(dq_valid),
    .pw_err(pw_err)
  );

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) nx();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle strobe event, returns at the following negedge
  task automatic evt(input logic r, input logic f, input logic ck);
    dqs_rise = r; dqs_fall = f; ck_level = ck;
    nx();
    dqs_rise = 1'b0; dqs_fall = 1'b0;
  endtask

  task automatic restart(input logic all, input logic [3:0] lat, input logic [7:0] oel);
    wl_en = 1'b0;
    idle(2);
    fb_all = all; out_lat = lat; oe_lat = oel;
    wl_en = 1'b1;
    idle(oel + 3);
  endtask

  task automatic t_reset();
    chk("R1 dq", dq, 0);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 dq_valid", dq_valid, 0);
    chk("R1 pw_err", pw_err, 0);
  endtask

  task automatic t_oe_delay(input logic [7:0] oel);
    int bad = 0;
    wl_en = 1'b0; idle(2);
    oe_lat = oel;
    wl_en = 1'b1;
    for (int i = 1; i <= oel + 2; i++) begin
      nx();
      if (dq_oe !== (i >= oel + 1)) bad++;
    end
    chk("R7 oe rise timing", bad, 0);
    wl_en = 1'b0;
    nx();
    chk("R7 oe falls on disable", dq_oe, 0);
  endtask

  task automatic t_capture(input logic [3:0] lat, input logic v, input logic all);
    int eff = (lat == 0) ? 1 : lat;
    logic [7:0] exp = all ? {8{v}} : {7'b0, v};
    int bad = 0;
    dqs_rise = 1'b1; ck_level = v;
    for (int i = 1; i <= eff + 2; i++) begin
      nx();
      dqs_rise = 1'b0; ck_level = ~v;
      if (dq_valid !== (i == eff + 1)) bad++;
      if (i == eff + 1) chk(all ? "R5 all-bits value" : "R4 prime-bit value", dq, exp);
    end
    chk("R2 R3 valid timing", bad, 0);
    chk("R6 value held", dq, exp);
  endtask

  task automatic t_disable_drops();
    int seen = 0;
    out_lat = 6;
    evt(1'b1, 1'b0, 1'b1);
    nx();
    wl_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      nx();
      if (dq_valid) seen++;
    end
    chk("R8 no valid after disable", seen, 0);
    chk("R8 dq zero", dq, 0);
    chk("R8 oe low", dq_oe, 0);
    wl_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      nx();
      if (dq_valid) seen++;
    end
    chk("R8 in-flight feedback discarded", seen, 0);
  endtask

  task automatic t_pw_high();
    restart(1'b0, 4'd2, 8'd0);
    min_high = 3; min_low = 2;
    evt(1'b1, 1'b0, 1'b0);
    idle(1);
    evt(1'b0, 1'b1, 1'b0);
    chk("R9 short high sets error", pw_err, 1);
    idle(4);
    chk("R11 error sticky", pw_err, 1);
    wl_en = 1'b0;
    nx();
    chk("R11 error clears on disable", pw_err, 0);
    restart(1'b0, 4'd2, 8'd0);
    evt(1'b1, 1'b0, 1'b0);
    idle(2);
    evt(1'b0, 1'b1, 1'b0);
    chk("R9 width equal to min accepted", pw_err, 0);
  endtask

  task automatic t_pw_low();
    // the rising event both ends a short low phase and captures feedback
    evt(1'b1, 1'b0, 1'b1);
    chk("R10 short low sets error", pw_err, 1);
    nx();
    chk("R2 no early valid", dq_valid, 0);
    nx();
    chk("R2 feedback of violating edge", dq_valid, 1);
    chk("R4 prime-bit value on violating edge", dq, 8'h01);
    restart(1'b0, 4'd2, 8'd0);
    evt(1'b1, 1'b0, 1'b0);
    idle(4);
    evt(1'b0, 1'b1, 1'b0);
    idle(1);
    evt(1'b1, 1'b0, 1'b0);
    chk("R10 width equal to min accepted", pw_err, 0);
  endtask

  task automatic t_exit(input logic [7:0] hold);
    int bad = 0;
    int seen = 0;
    restart(1'b0, 4'd1, 8'd0);
    exit_hold = hold;
    wl_exit = 1'b1;
    for (int i = 1; i <= hold + 3; i++) begin
      nx();
      wl_exit = 1'b0;
      if (dq_oe !== (i >= hold + 2)) bad++;
      if (dq_valid) seen++;
    end
    chk("R12 enable ignored during guard", bad, 0);
    chk("R12 no feedback during guard", seen, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wl_en = 1'b0; wl_exit = 1'b0; fb_all = 1'b0; ck_level = 1'b0;
    dqs_rise = 1'b0; dqs_fall = 1'b0; out_lat = 4'd1; oe_lat = 8'd0;
    min_high = 8'd1; min_low = 8'd1; exit_hold = 8'd0;
    idle(3);
    rst = 1'b0;
    nx();
    t_reset();
    t_oe_delay(8'd3);
    t_oe_delay(8'd0);
    restart(1'b0, 4'd1, 8'd0);
    t_capture(4'd1, 1'b1, 1'b0);
    t_capture(4'd1, 1'b0, 1'b0);
    restart(1'b0, 4'd4, 8'd2);
    t_capture(4'd4, 1'b1, 1'b0);
    restart(1'b0, 4'd0, 8'd0);
    t_capture(4'd0, 1'b1, 1'b0);
    restart(1'b1, 4'd3, 8'd1);
    t_capture(4'd3, 1'b1, 1'b1);
    t_capture(4'd3, 1'b0, 1'b1);
    restart(1'b0, 4'd15, 8'd0);
    t_capture(4'd15, 1'b1, 1'b0);
    restart(1'b0, 4'd6, 8'd0);
    t_disable_drops();
    t_pw_high();
    t_pw_low();
    t_exit(8'd5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule